// File: doc/BRIEF.md
# Three-Port Pin Controller

This block is a register-mapped controller for nine bidirectional pins. The pins are split into three ports: port 0 is five pins wide, and ports 1 and 2 are two pins wide each. Each port has four registers on a simple single-cycle bus. The first is a function-select register. The second is a combined register that holds the drive enables, the output levels and the sampled input levels. The third sets output bits and the fourth clears them. Writes take effect at the clock edge. Reads are combinational from the address.

Pin inputs pass through a synchronizer. The synchronized levels feed the input readback field. Four of those levels also go out as unlatched, active-high, level-sensitive interrupt requests to an interrupt controller outside this block. A power-down input freezes the pad-side enables and levels. Register state stays intact during power-down, and writes still land in the registers.

A non-zero function select on a pin hands that pin's pad signals to an alternate-function source.

Top module: `pinctl_top`

## Requirements
- R1: Global pin numbering is port 0 on pins 0 to 4, port 1 on pins 5 and 6, and port 2 on pins 7 and 8. The bus address is split as follows: `bus_addr[3:2]` selects the port, and `bus_addr[1:0]` selects the register (0 = function select, 1 = combined data, 2 = set, 3 = clear).
- R2: Reset clears every function select, drive enable and output level. `pin_oe`, `pin_out` and `irq` are all zero after reset.
- R3: A write to the combined register loads the drive enables from bits [31:24] and the output levels from bits [23:16]. Reading it back returns those fields in the same positions. Bits for pins that a port lacks, and bits [15:8], always read as zero.
- R4: A write to the set register sets each output level whose bit in [23:16] is 1. Bits that are 0 leave their level unchanged, and the drive enables are untouched.
- R5: A write to the clear register clears each output level whose bit in [23:16] is 1. Bits that are 0 leave their level unchanged.
- R6: Bits [7:0] of the combined register return the pin input levels through a two-flop synchronizer. A change at the pin becomes visible after the second rising clock edge.
- R7: `irq[3:0]` carries the synchronized levels of global pins 0, 5, 7 and 8, in that order from bit 0. The requests are not latched: each one falls two edges after its pin falls. A pin high for a single clock is still seen.
- R8: The function-select register holds two bits per pin, with pin i of the port at bits [2i+1:2i]. Bits for absent pins read as zero. A value of 0 drives the pad from the registers. Any other value drives `pin_oe` and `pin_out` from `alt_oe` and `alt_out`.
- R9: While `pwr_down` is high, `pin_oe` and `pin_out` keep the values they had in the cycle before it rose. This holds even when a write lands in the same cycle as the rise. Registers still accept writes, and the pads follow the registers as soon as `pwr_down` falls.
- R10: Reads of the set and clear registers return zero. Addresses with port field 3 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Port select [3:2] and register select [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 9 | Pad input levels |
| alt_oe | input | 9 | Drive enables from alternate functions |
| alt_out | input | 9 | Output levels from alternate functions |
| pwr_down | input | 1 | Freezes the pad outputs while high |
| pin_oe | output | 9 | Pad drive enables |
| pin_out | output | 9 | Pad output levels |
| irq | output | 4 | Level requests for pins 0, 5, 7, 8 |

## Verification
The interesting collision is a bus write in the same cycle that `pwr_down` rises. The register must take the new value while the pads keep the old one. The bench raises `pwr_down` and writes new enables and levels to port 0 in the same cycle. It then checks the pads against the values from before the write, and the readback against the written value. When power-down ends, it checks that the pads switch to the register contents in that same cycle. A second overlap comes from a set write landing while pins are changing. The bench watches the synchronized readback and `irq` at the exact edge counts that R6 and R7 call for.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    function automatic int port_w(input int p);
        case (p)
            0:       return 5;
            1, 2:    return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int port_base(input int p);
        int s;
        s = 0;
        for (int i = 0; i < p; i++) s += port_w(i);
        return s;
    endfunction

    localparam int NPORT = 3;
    localparam int NPIN  = port_base(NPORT);
    localparam int MAXW  = 8;
    localparam int DW    = 32;
    localparam logic [NPIN-1:0] IRQ_PINS = 9'h1A1;

    function automatic int irq_count();
        int c;
        c = 0;
        for (int i = 0; i < NPIN; i++) if (IRQ_PINS[i]) c++;
        return c;
    endfunction

    function automatic int irq_pin(input int k);
        int c;
        c = 0;
        for (int i = 0; i < NPIN; i++) begin
            if (IRQ_PINS[i]) begin
                if (c == k) return i;
                c++;
            end
        end
        return 0;
    endfunction

    localparam int NIRQ = irq_count();

    typedef enum logic [1:0] {
        REG_FSEL = 2'd0,
        REG_DATA = 2'd1,
        REG_SET  = 2'd2,
        REG_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2*MAXW-1:0] fsel;
        logic [MAXW-1:0]   oe;
        logic [MAXW-1:0]   lvl;
    } port_state_t;

    typedef struct packed {
        logic [NPIN-1:0] oe;
        logic [NPIN-1:0] lvl;
    } pad_hold_t;

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/pinctl_port.sv
module pinctl_port
    import pinctl_pkg::*;
#(
    parameter int W = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  pin_sync,
    input  logic [W-1:0]  alt_oe,
    input  logic [W-1:0]  alt_out,
    output logic [DW-1:0] rdata,
    output logic [W-1:0]  live_oe,
    output logic [W-1:0]  live_out
);
    localparam logic [MAXW-1:0]   PMASK = MAXW'((1 << W) - 1);
    localparam logic [2*MAXW-1:0] FMASK = (2*MAXW)'((1 << (2*W)) - 1);

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_sel_e'(reg_sel))
                REG_FSEL: st_d.fsel = wdata[2*MAXW-1:0] & FMASK;
                REG_DATA: begin
                    st_d.oe  = wdata[31:24] & PMASK;
                    st_d.lvl = wdata[23:16] & PMASK;
                end
                REG_SET:  st_d.lvl = st_q.lvl | (wdata[23:16] & PMASK);
                REG_CLR:  st_d.lvl = st_q.lvl & ~wdata[23:16];
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            REG_FSEL: rdata = {{(DW-2*MAXW){1'b0}}, st_q.fsel};
            REG_DATA: rdata = {st_q.oe, st_q.lvl, 8'h00, MAXW'(pin_sync)};
            default:  rdata = '0;
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic use_alt;
        assign use_alt     = |st_q.fsel[2*i +: 2];
        assign live_oe[i]  = use_alt ? alt_oe[i]  : st_q.oe[i];
        assign live_out[i] = use_alt ? alt_out[i] : st_q.lvl[i];
    end
endmodule

// File: rtl/pinctl_top.sv
module pinctl_top
    import pinctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] alt_oe,
    input  logic [NPIN-1:0] alt_out,
    input  logic            pwr_down,
    output logic [NPIN-1:0] pin_oe,
    output logic [NPIN-1:0] pin_out,
    output logic [NIRQ-1:0] irq
);
    localparam int PIW = AW - 2;

    logic [NPIN-1:0] sync_lvl;
    logic [NPIN-1:0] live_oe, live_out;
    logic [DW-1:0]   prd [NPORT];
    logic [PIW-1:0]  port_idx;
    pad_hold_t       hold_d, hold_q;

    assign port_idx = bus_addr[AW-1:2];

    pinctl_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (sync_lvl)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam int W = port_w(g);
        localparam int B = port_base(g);
        logic hit;
        assign hit = (port_idx == PIW'(g));

        pinctl_port #(.W(W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && hit),
            .reg_sel (bus_addr[1:0]),
            .wdata   (bus_wdata),
            .pin_sync(sync_lvl[B +: W]),
            .alt_oe  (alt_oe[B +: W]),
            .alt_out (alt_out[B +: W]),
            .rdata   (prd[g]),
            .live_oe (live_oe[B +: W]),
            .live_out(live_out[B +: W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (port_idx == PIW'(p)) bus_rdata = prd[p];
        end
    end

    always_comb begin
        hold_d = hold_q;
        if (!pwr_down) begin
            hold_d.oe  = live_oe;
            hold_d.lvl = live_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign pin_oe  = pwr_down ? hold_q.oe  : live_oe;
    assign pin_out = pwr_down ? hold_q.lvl : live_out;

    for (genvar k = 0; k < NIRQ; k++) begin : g_irq
        assign irq[k] = sync_lvl[irq_pin(k)];
    end
endmodule

// File: rtl/pinctl_chk.sv
module pinctl_chk
    import pinctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [NPIN-1:0] pin_in,
    input logic            pwr_down,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] pin_out,
    input logic [NIRQ-1:0] irq
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && irq == '0));

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> ($stable(pin_oe) && $stable(pin_out)));

    // R10
    bad_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr[AW-1:2]) >= NPORT) |-> (bus_rdata == '0));

    // R3
    data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(1)) |=>
            (bus_addr != AW'(1) || bus_rdata[31:16] == ($past(bus_wdata[31:16]) & 16'h1F1F)));

    if (SYNC_STAGES == 2) begin : g_sync2
        // R7
        irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2) |-> (irq == {$past(pin_in[8], 2), $past(pin_in[7], 2),
                                         $past(pin_in[5], 2), $past(pin_in[0], 2)}));

        // R6
        readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && bus_addr == AW'(1)) |->
                (bus_rdata[4:0] == $past(pin_in[4:0], 2) && bus_rdata[15:5] == '0));
    end
endmodule

bind pinctl_top pinctl_chk #(.SYNC_STAGES(SYNC_STAGES), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pwr_down (pwr_down),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .irq      (irq)
);

// File: tb/pinctl_top_bench.sv
module pinctl_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  pin_in = '0;
    logic [8:0]  alt_oe = '0;
    logic [8:0]  alt_out = '0;
    logic        pwr_down = 1'b0;
    logic [8:0]  pin_oe, pin_out;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pinctl_top u_pinctl_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_oe(alt_oe), .alt_out(alt_out), .pwr_down(pwr_down),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [31:0] ex;
        logic [31:0] tag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'h1, 32'hFFFF_FFFF, 4'h1, 32'h1F1F_0000, "R3"},
        '{4'h3, 32'h0005_0000, 4'h1, 32'h1F1A_0000, "R5"},
        '{4'h2, 32'h0001_0000, 4'h1, 32'h1F1B_0000, "R4"},
        '{4'h2, 32'h0000_0000, 4'h1, 32'h1F1B_0000, "R4"},
        '{4'h5, 32'h0203_0000, 4'h5, 32'h0203_0000, "R3"},
        '{4'h7, 32'h0001_0000, 4'h5, 32'h0202_0000, "R5"},
        '{4'h9, 32'h0301_0000, 4'h9, 32'h0301_0000, "R1"},
        '{4'hD, 32'hFFFF_FFFF, 4'hD, 32'h0000_0000, "R10"},
        '{4'h0, 32'hFFFF_FFFF, 4'h0, 32'h0000_03FF, "R8"},
        '{4'h0, 32'h0000_0000, 4'h0, 32'h0000_0000, "R8"},
        '{4'h8, 32'h0000_000F, 4'h8, 32'h0000_000F, "R8"},
        '{4'h6, 32'hFFFF_FFFF, 4'h6, 32'h0000_0000, "R10"}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2 pin_oe", 32'(pin_oe), 32'h0);
        chk("R2 pin_out", 32'(pin_out), 32'h0);
        chk("R2 irq", 32'(irq), 32'h0);
        bus_read(4'h1, rd);
        chk("R2 data", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i].wa, VEC[i].wd);
            bus_read(VEC[i].ra, rd);
            chk($sformatf("%s vec%0d", VEC[i].tag, i), rd, VEC[i].ex);
        end

        // R8 port 2 on alternate function with alt inputs low
        chk("R8 pin_oe alt0", 32'(pin_oe), 32'h05F);
        chk("R8 pin_out alt0", 32'(pin_out), 32'h07B);
        alt_oe = 9'h1FF; alt_out = 9'h180;
        #1;
        chk("R8 pin_oe alt1", 32'(pin_oe), 32'h1DF);
        chk("R8 pin_out alt1", 32'(pin_out), 32'h1FB);
        bus_write(4'h8, 32'h0);
        #1;
        chk("R8 pin_oe gpio", 32'(pin_oe), 32'h1DF);
        chk("R8 pin_out gpio", 32'(pin_out), 32'h0FB);

        // R6 synchronizer latency
        @(negedge clk);
        pin_in = 9'h1FF;
        @(negedge clk);
        bus_read(4'h1, rd);
        chk("R6 one edge", {24'h0, rd[7:0]}, 32'h0);
        @(negedge clk);
        bus_read(4'h1, rd);
        chk("R6 port0 in", {24'h0, rd[7:0]}, 32'h1F);
        bus_read(4'h5, rd);
        chk("R6 port1 in", {24'h0, rd[7:0]}, 32'h03);
        bus_read(4'h9, rd);
        chk("R6 port2 in", {24'h0, rd[7:0]}, 32'h03);
        chk("R7 all high", 32'(irq), 32'hF);

        // R7 level mapping and no latching
        pin_in = 9'h120;
        repeat (2) @(negedge clk);
        chk("R7 pins5_8", 32'(irq), 32'hA);
        pin_in = 9'h000;
        @(negedge clk);
        chk("R7 lag", 32'(irq), 32'hA);
        @(negedge clk);
        chk("R7 unlatched", 32'(irq), 32'h0);
        pin_in = 9'h001;
        @(negedge clk);
        pin_in = 9'h000;
        @(negedge clk);
        chk("R7 one-cycle pulse", 32'(irq), 32'h1);
        @(negedge clk);
        chk("R7 pulse gone", 32'(irq), 32'h0);

        // R9 write lands in the cycle power-down rises
        pwr_down = 1'b1;
        bus_wr = 1'b1; bus_addr = 4'h1; bus_wdata = 32'h0004_0000;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R9 oe held", 32'(pin_oe[4:0]), 32'h1F);
        chk("R9 out held", 32'(pin_out[4:0]), 32'h1B);
        bus_read(4'h1, rd);
        chk("R9 reg written", rd, 32'h0004_0000);
        bus_write(4'h2, 32'h0003_0000);
        repeat (3) @(negedge clk);
        chk("R9 out still held", 32'(pin_out[4:0]), 32'h1B);
        pwr_down = 1'b0;
        #1;
        chk("R9 oe released", 32'(pin_oe[4:0]), 32'h00);
        chk("R9 out released", 32'(pin_out[4:0]), 32'h07);

        finish_run();
    end
endmodule